// File: doc/BRIEF.md
# Word-Parallel CRC-16 with Partial Final Word

This block computes a 16-bit cyclic redundancy check over a byte stream that arrives as 32-bit words, one word per clock. A typical use is recomputing the integrity checksum of a configuration image after some of its contents have been edited, before the image is sent on.

Full words are folded into the CRC register in a single cycle. The final word of a frame may carry one, two or three valid bytes. That word is also absorbed in one cycle, through an 8-, 16- or 24-bit fold of the same register state. Frames of any byte length therefore finish without a bit-serial tail. The result gives the same value as a one-bit-at-a-time computation over the same bytes. Output reflection, output inversion and the initial register value are parameters.

Top module: `crc16_ragged`

## Requirements
- R1: The generator polynomial is x^16 + x^15 + x^2 + 1 (0x8005), without reflection of the input. Within a 32-bit word the byte in bits 31:24 goes first, and each byte goes in most significant bit first. The result equals a bit-serial shift register fed in that order.
- R2: On a final word with `in_bytes` of 1, 2 or 3, only that many bytes are folded in. They sit in the upper byte lanes starting at bits 31:24, and the unused lower lanes do not affect the result.
- R3: A word with `in_start` high folds from the initial value INIT (default 0x0000), whatever earlier frames left in the register. Back-to-back frames are therefore independent.
- R4: A word with both `in_start` and `in_last` high is a complete single-word frame.
- R5: `crc_done` is high for exactly the one cycle after the final word is accepted (`in_valid` and `in_last`), and is low otherwise.
- R6: `crc_out` changes only in the cycle that `crc_done` rises. It holds the last result while the next frame streams in.
- R7: `in_bytes` of 0 means four valid bytes. `in_bytes` is ignored on words with `in_last` low, and those words always fold all four bytes.
- R8: With REFLECT_OUT set, the 16 result bits are reversed. With INVERT_OUT set, the result is XORed with 0xFFFF. Reversal is applied before inversion. Both are off by default.
- R9: After reset, `crc_out` is 0x0000 and `crc_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A data word is presented this cycle |
| in_start | input | 1 | First word of a frame |
| in_last | input | 1 | Final word of a frame |
| in_bytes | input | 2 | Valid bytes in a final word; 0 means four |
| in_data | input | 32 | Data word, first byte in bits 31:24 |
| crc_out | output | 16 | Result of the latest finished frame |
| crc_done | output | 1 | One-cycle strobe: `crc_out` has just been updated |

## Verification
Every frame length from 1 to 64 bytes is run. This covers each of the four final-word sizes, several times over, after zero to fifteen full words. A wrong fold equation for one size, or a finishing path that restarts instead of continuing, shows up only on lengths with that remainder. The unused byte lanes are filled with junk, and the non-final words carry nonzero byte counts, so that leaks from ignored inputs are caught. Gap cycles between words and back-to-back frames separate hold and restart faults from fold faults. A second instance runs with a nonzero initial value, reflection and inversion, so that the post-processing order is checked against the same serial model.

// File: rtl/crc16_ragged.sv
module crc16_ragged #(
  parameter int          DW          = 32,
  parameter int          CW          = 16,
  parameter logic [15:0] POLY        = 16'h8005,
  parameter logic [15:0] INIT        = 16'h0000,
  parameter bit          REFLECT_OUT = 1'b0,
  parameter bit          INVERT_OUT  = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_start,
  input  logic          in_last,
  input  logic [1:0]    in_bytes,
  input  logic [31:0]   in_data,
  output logic [15:0]   crc_out,
  output logic          crc_done
);
  localparam int LANES = DW / 8;
  localparam int BW    = $clog2(LANES);

  function automatic logic [CW-1:0] fold(input logic [CW-1:0] c,
                                         input logic [DW-1:0] d,
                                         input int nbits);
    logic [CW-1:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < DW; i++) begin
      if (i < nbits) begin
        fb = r[CW-1] ^ d[DW-1-i];
        r  = {r[CW-2:0], 1'b0} ^ (fb ? POLY : '0);
      end
    end
    return r;
  endfunction

  logic [CW-1:0] state_q, res_q, base, nxt, refl, fin;
  logic [CW-1:0] path [LANES];
  logic [BW-1:0] sel;
  logic          done_q;

  assign base = in_start ? INIT : state_q;

  for (genvar k = 1; k <= LANES; k++) begin : g_path
    assign path[k-1] = fold(base, in_data, k * 8);
  end

  assign sel = (in_last && in_bytes != '0) ? in_bytes - 1'b1 : BW'(LANES - 1);
  assign nxt = path[sel];

  for (genvar b = 0; b < CW; b++) begin : g_refl
    assign refl[b] = nxt[CW-1-b];
  end

  assign fin = (REFLECT_OUT ? refl : nxt) ^ (INVERT_OUT ? {CW{1'b1}} : {CW{1'b0}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= '0;
      res_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= in_valid && in_last;
      if (in_valid) state_q <= nxt;
      if (in_valid && in_last) res_q <= fin;
    end
  end

  assign crc_out  = res_q;
  assign crc_done = done_q;

  p_done_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_last |=> crc_done);
  p_no_spurious_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_last) |=> !crc_done);
  p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_last) |=> $stable(crc_out));
  p_single_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_start && in_last |=> crc_done);
endmodule

// File: tb/tb_crc16_ragged.sv
module tb_crc16_ragged;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_start = 0, in_last = 0;
  logic [1:0]  in_bytes = 0;
  logic [31:0] in_data = 0;
  logic [15:0] crc_a, crc_b;
  logic        done_a, done_b;
  int checks = 0, errors = 0;
  logic [15:0] prev_a = 16'h0000, prev_b = 16'h0000;
  logic [7:0] fbytes [64];

  always #2.5 clk = ~clk;

  crc16_ragged dut (.clk, .rst_n, .in_valid, .in_start, .in_last, .in_bytes,
    .in_data, .crc_out(crc_a), .crc_done(done_a));
  crc16_ragged #(.INIT(16'hFFFF), .REFLECT_OUT(1'b1), .INVERT_OUT(1'b1)) dut2 (
    .clk, .rst_n, .in_valid, .in_start, .in_last, .in_bytes,
    .in_data, .crc_out(crc_b), .crc_done(done_b));

  function automatic logic [15:0] serial_crc(input logic [15:0] init, input int len);
    logic [15:0] c = init;
    logic fb;
    for (int i = 0; i < len; i++)
      for (int j = 7; j >= 0; j--) begin
        fb = c[15] ^ fbytes[i][j];
        c  = {c[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
      end
    return c;
  endfunction

  function automatic logic [15:0] rev16(input logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[15-i];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reset_check();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 crc_out after reset", crc_a, 16'h0000);
    check("R9 crc_done after reset", done_a, 1'b0);
    check("R9 second instance after reset", {crc_b, 15'd0, done_b}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_frame(input int len, input int seed, input bit gaps, input bit noisy);
    int nw = (len + 3) / 4;
    logic [15:0] ea, eb;
    for (int i = 0; i < len; i++) fbytes[i] = 8'((seed * 37 + i * 91 + 5) ^ (i << 3));
    ea = serial_crc(16'h0000, len);
    eb = ~rev16(serial_crc(16'hFFFF, len));
    for (int w = 0; w < nw; w++) begin
      logic [31:0] word = 32'hA5A5A5A5;
      for (int k = 0; k < 4; k++)
        if (w * 4 + k < len) word[31-8*k -: 8] = fbytes[w*4+k];
      if (w == nw - 1) begin
        check("R6 result held during next frame", crc_a, prev_a);
        check("R5 no strobe mid-frame", done_a, 1'b0);
      end
      in_valid = 1; in_data = word;
      in_start = (w == 0); in_last = (w == nw - 1);
      in_bytes = (w == nw - 1) ? 2'(len % 4) : (noisy ? 2'(w % 3 + 1) : 2'd0);
      @(negedge clk);
      in_valid = 0; in_start = 0; in_last = 0; in_data = 32'hDEADBEEF; in_bytes = 2'd2;
      if (w == nw - 1) begin
        check($sformatf("R1 R2 R7 crc len=%0d", len), crc_a, ea);
        check("R5 strobe after last", done_a, 1'b1);
        check($sformatf("R8 reflect+invert len=%0d", len), crc_b, eb);
        if (nw == 1) check("R4 single-word frame", crc_a, ea);
        @(negedge clk);
        check("R5 strobe one cycle", done_a, 1'b0);
        check("R6 held after strobe", crc_a, ea);
      end else if (gaps) begin
        repeat (2) @(negedge clk);
      end
    end
    prev_a = ea; prev_b = eb;
  endtask

  task automatic lengths_sweep();
    for (int len = 1; len <= 64; len++) run_frame(len, len, 1'b0, 1'b0);
  endtask

  task automatic gaps_and_noisy_counts();
    run_frame(23, 7, 1'b1, 1'b1);
    run_frame(40, 9, 1'b1, 1'b1);
  endtask

  task automatic restart_independence();
    // R3: same bytes after a different frame must give the same value
    run_frame(13, 3, 1'b0, 1'b0);
    run_frame(6, 11, 1'b0, 1'b0);
    run_frame(13, 3, 1'b0, 1'b0);
    check("R3 restart from INIT", crc_a, serial_crc(16'h0000, 13));
  endtask

  initial begin
    reset_check();
    lengths_sweep();
    gaps_and_noisy_counts();
    restart_independence();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule